// File: doc/BRIEF.md
# Write-Only Two-Wire Slave Receiver with Channel Burst

This block is the receive side of a two-wire (I2C) serial port for a multichannel DAC. It watches the clock and data lines in the system clock domain, recognises START and STOP conditions, accepts a device address whose two lowest address bits come from strap pins, and acknowledges every byte it takes. Each completed update is presented as a one-cycle pulse carrying a channel number, a two-bit register-kind field and a data word. The register file behind it is not part of this block.

Three framings share one state machine. The first is a full frame: address, pointer, then two data bytes. The second repeats pointer-plus-data pairs after one address byte. The third is a burst: the reserved pointer value 0xFF starts at channel 0, and each data pair then writes the next channel. After the highest channel, the block returns to expecting a pointer byte. A STOP ends any framing, and a repeated START makes the block expect an address byte again.

The block only receives. It never stretches the clock. Data is driven open drain: the `sda_oe` output pulls the line low when it is 1.

Top module: `dac_i2c_burst_rx`

## Requirements
- R1: After reset `sda_oe` is 0 and `upd_valid` is 0. No update appears while the block is idle.
- R2: An address byte whose bits 7:3 are 10101, whose bits 2:1 equal `addr_pins` and whose bit 0 (direction) is 0 is acknowledged: `sda_oe` is 1 during the ninth clock.
- R3: An address byte that does not match, or that has bit 0 = 1, is not acknowledged. Every byte after it goes unacknowledged and produces no update until the next START.
- R4: After a matched address, every pointer byte and every data byte is acknowledged. `upd_valid` is only ever high while the acknowledge of the last data byte is being driven.
- R5: A pointer byte other than 0xFF selects channel `pointer[CHAN_W-1:0]`. The next two data bytes form a 16-bit word, first byte most significant. The update carries `upd_kind` = word[15:14] and `upd_data` = word[DATA_W-1:0].
- R6: Without a STOP, another pointer byte followed by two data bytes produces a further update without a new address byte.
- R7: Pointer 0xFF starts a burst at channel 0. Each pair of data bytes updates the current channel, and the next pair goes to the channel one higher.
- R8: After the pair for channel NUM_CHAN-1, the next byte is taken as a pointer byte.
- R9: A STOP or repeated START discards a half-received update. After a repeated START, the next byte is treated as an address byte.
- R10: Each update is a single-cycle pulse on `upd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| addr_pins | input | 2 | Strap value for address bits 2:1 |
| upd_valid | output | 1 | One-cycle pulse per completed update |
| upd_chan | output | CHAN_W | Channel number of the update |
| upd_kind | output | 2 | Register-kind field, word bits 15:14 |
| upd_data | output | DATA_W | Data word of the update |

## Verification
A wrong frame state shows at the ports within one byte time. A missed or extra acknowledge appears on the data line in the ninth clock of the affected byte. A wrong burst channel counter shows in the `upd_chan` of the very next update. A half-word that survives a STOP or repeated START produces an update the scoreboard did not expect, or a wrong word, on the next data pair. A stuck address matcher shows up as a missing acknowledge on the first byte after START.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;

   // fixed upper part of the device address; the two low bits come from straps
   localparam logic [4:0] DEV_ADDR_HI = 5'b10101;
   // pointer value that starts the auto-incrementing channel burst
   localparam logic [7:0] BURST_CODE  = 8'hFF;
   // width of the assembled two-byte data word
   localparam int         WORD_W      = 16;
   localparam int         KIND_W      = 2;

   // position of the frame controller inside a transaction
   typedef enum logic [2:0] {
      FS_IDLE,
      FS_ADDR,
      FS_PTR,
      FS_DHI,
      FS_DLO
   } frame_state_t;

   // position of the byte engine inside a byte
   typedef enum logic [1:0] {
      BP_IDLE,
      BP_DATA,
      BP_ACK
   } bit_phase_t;

endpackage

// File: rtl/i2c_bus_cond.sv
// Synchronises the two bus lines and derives edge and bus-condition strobes.
module i2c_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int LINES = 2;
   localparam int IDX_SCL = 1;
   localparam int IDX_SDA = 0;

   logic [LINES-1:0] raw_in;
   logic [LINES-1:0] sync_v;
   logic [LINES-1:0] prev_q;

   assign raw_in = {scl_i, sda_i};

   // one synchroniser chain per line, idle level is high
   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_in[g]};
      end
      assign sync_v[g] = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= sync_v;
   end

   logic scl_now, sda_now, scl_prev, sda_prev;
   assign scl_now  = sync_v[IDX_SCL];
   assign sda_now  = sync_v[IDX_SDA];
   assign scl_prev = prev_q[IDX_SCL];
   assign sda_prev = prev_q[IDX_SDA];

   assign sda_lvl   = sda_now;
   assign scl_rise  = scl_now & ~scl_prev;
   assign scl_fall  = ~scl_now & scl_prev;
   // data edges while the clock stays high mark bus conditions
   assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
   assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_byte_shift.sv
// Shifts in eight bits per byte and drives the acknowledge on the ninth clock.
module i2c_byte_shift
   import dac_i2c_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_lvl,
   input  logic       ack_en,
   output logic       byte_stb,
   output logic [7:0] byte_val,
   output logic       sda_oe
);

   localparam int          BITS    = 8;
   localparam int          CNT_W   = $clog2(BITS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

   bit_phase_t       phase_q;
   logic [CNT_W-1:0] bit_cnt_q;
   logic [BITS-1:0]  shreg_q;

   assign byte_val = shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= BP_IDLE;
         bit_cnt_q <= '0;
         shreg_q   <= '0;
         byte_stb  <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         if (start_det) begin
            // a START (first or repeated) always restarts bit counting
            phase_q   <= BP_DATA;
            bit_cnt_q <= '0;
            sda_oe    <= 1'b0;
         end else if (stop_det) begin
            phase_q <= BP_IDLE;
            sda_oe  <= 1'b0;
         end else begin
            case (phase_q)
               BP_DATA: begin
                  if (scl_rise && bit_cnt_q != FULL) begin
                     shreg_q   <= {shreg_q[BITS-2:0], sda_lvl};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
                  if (scl_fall && bit_cnt_q == FULL) begin
                     byte_stb <= 1'b1;
                     phase_q  <= BP_ACK;
                  end
               end
               BP_ACK: begin
                  // controller answers in the strobe cycle
                  if (byte_stb) sda_oe <= ack_en;
                  if (scl_fall) begin
                     sda_oe    <= 1'b0;
                     bit_cnt_q <= '0;
                     // a refused byte leaves the bus alone until the next START
                     phase_q   <= sda_oe ? BP_DATA : BP_IDLE;
                  end
               end
               default: begin
                  phase_q <= BP_IDLE;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_frame_ctl.sv
// Decodes address, pointer and data bytes into channel updates.
module i2c_frame_ctl
   import dac_i2c_pkg::*;
#(
   parameter  int NUM_CHAN = 16,
   parameter  int DATA_W   = 14,
   localparam int CHAN_W   = $clog2(NUM_CHAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              byte_stb,
   input  logic [7:0]        byte_val,
   input  logic [1:0]        addr_pins,
   output logic              ack_en,
   output logic              ctl_idle,
   output logic              upd_valid,
   output logic [CHAN_W-1:0] upd_chan,
   output logic [KIND_W-1:0] upd_kind,
   output logic [DATA_W-1:0] upd_data
);

   localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(NUM_CHAN - 1);

   frame_state_t      st_q;
   logic              burst_q;
   logic [CHAN_W-1:0] chan_q;
   logic [7:0]        hi_q;
   logic              addr_hit;
   logic [WORD_W-1:0] word;

   assign addr_hit = (byte_val[7:3] == DEV_ADDR_HI) &&
                     (byte_val[2:1] == addr_pins) &&
                     !byte_val[0];
   assign word     = {hi_q, byte_val};
   assign ctl_idle = (st_q == FS_IDLE);

   always_comb begin
      case (st_q)
         FS_IDLE: ack_en = 1'b0;
         FS_ADDR: ack_en = addr_hit;
         default: ack_en = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FS_IDLE;
         burst_q   <= 1'b0;
         chan_q    <= '0;
         hi_q      <= '0;
         upd_valid <= 1'b0;
         upd_chan  <= '0;
         upd_kind  <= '0;
         upd_data  <= '0;
      end else begin
         upd_valid <= 1'b0;
         if (start_det) begin
            st_q    <= FS_ADDR;
            burst_q <= 1'b0;
         end else if (stop_det) begin
            st_q    <= FS_IDLE;
            burst_q <= 1'b0;
         end else if (byte_stb) begin
            case (st_q)
               FS_ADDR: st_q <= addr_hit ? FS_PTR : FS_IDLE;
               FS_PTR: begin
                  if (byte_val == BURST_CODE) begin
                     burst_q <= 1'b1;
                     chan_q  <= '0;
                  end else begin
                     burst_q <= 1'b0;
                     chan_q  <= byte_val[CHAN_W-1:0];
                  end
                  st_q <= FS_DHI;
               end
               FS_DHI: begin
                  hi_q <= byte_val;
                  st_q <= FS_DLO;
               end
               FS_DLO: begin
                  upd_valid <= 1'b1;
                  upd_chan  <= chan_q;
                  upd_kind  <= word[WORD_W-1 -: KIND_W];
                  upd_data  <= word[DATA_W-1:0];
                  if (burst_q && chan_q != LAST_CHAN) begin
                     chan_q <= chan_q + 1'b1;
                     st_q   <= FS_DHI;
                  end else begin
                     burst_q <= 1'b0;
                     st_q    <= FS_PTR;
                  end
               end
               default: st_q <= FS_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/dac_i2c_burst_rx.sv
// Top: write-only two-wire slave receiver for a multichannel converter.
module dac_i2c_burst_rx
   import dac_i2c_pkg::*;
#(
   parameter  int NUM_CHAN    = 16,
   parameter  int DATA_W      = 14,
   parameter  int SYNC_STAGES = 2,
   localparam int CHAN_W      = $clog2(NUM_CHAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        addr_pins,
   output logic              upd_valid,
   output logic [CHAN_W-1:0] upd_chan,
   output logic [1:0]        upd_kind,
   output logic [DATA_W-1:0] upd_data
);

   // elaboration-time parameter checks
   if (NUM_CHAN < 2 || NUM_CHAN > 128 || (NUM_CHAN & (NUM_CHAN - 1)) != 0) begin : g_bad_chan
      $error("NUM_CHAN must be a power of two between 2 and 128");
   end
   if (DATA_W < 1 || DATA_W > WORD_W - KIND_W) begin : g_bad_data
      $error("DATA_W must lie between 1 and 14");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic       byte_stb, ack_en, ctl_idle;
   logic [7:0] byte_val;

   i2c_bus_cond #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_byte_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_det (start_det),
      .stop_det  (stop_det),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_lvl   (sda_lvl),
      .ack_en    (ack_en),
      .byte_stb  (byte_stb),
      .byte_val  (byte_val),
      .sda_oe    (sda_oe)
   );

   i2c_frame_ctl #(
      .NUM_CHAN (NUM_CHAN),
      .DATA_W   (DATA_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_det (start_det),
      .stop_det  (stop_det),
      .byte_stb  (byte_stb),
      .byte_val  (byte_val),
      .addr_pins (addr_pins),
      .ack_en    (ack_en),
      .ctl_idle  (ctl_idle),
      .upd_valid (upd_valid),
      .upd_chan  (upd_chan),
      .upd_kind  (upd_kind),
      .upd_data  (upd_data)
   );

endmodule

// File: rtl/dac_i2c_burst_rx_chk.sv
// Protocol checker bound to the receiver top.
module dac_i2c_burst_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic upd_valid,
   input logic ctl_idle
);

   // consecutive cycles with the raw clock line high, saturating
   logic [2:0] scl_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  scl_hi_cnt <= '0;
      else if (!scl_i)             scl_hi_cnt <= '0;
      else if (scl_hi_cnt != 3'd7) scl_hi_cnt <= scl_hi_cnt + 1'b1;
   end

   // R10: an update is a single-cycle pulse
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> !upd_valid);

   // R4: updates only appear while the last data byte is being acknowledged
   a_r4_update_acked: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> sda_oe);

   // R4: the acknowledge never changes while the bus clock is settled high
   a_r4_oe_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_hi_cnt >= 3'd2) |-> $stable(sda_oe));

   // R3: an idle controller never drives the line
   a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_idle |-> !sda_oe);

   // R1: no update while idle
   a_r1_idle_no_update: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_idle |-> !upd_valid);

endmodule

bind dac_i2c_burst_rx dac_i2c_burst_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe    (sda_oe),
   .upd_valid (upd_valid),
   .ctl_idle  (ctl_idle)
);

// File: tb/tb_dac_i2c_burst_rx.sv
`timescale 1ns/1ps
module tb_dac_i2c_burst_rx;

   localparam int NUM_CHAN = 16;
   localparam int DATA_W   = 14;
   localparam int CHAN_W   = $clog2(NUM_CHAN);
   localparam int Q        = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              m_scl = 1'b1;
   logic              m_sda = 1'b1;
   logic [1:0]        addr_pins = 2'b10;
   logic              sda_oe;
   logic              upd_valid;
   logic [CHAN_W-1:0] upd_chan;
   logic [1:0]        upd_kind;
   logic [DATA_W-1:0] upd_data;
   logic              sda_bus;

   // open-drain wired AND of master and slave
   assign sda_bus = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   dac_i2c_burst_rx #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .addr_pins (addr_pins),
      .upd_valid (upd_valid),
      .upd_chan  (upd_chan),
      .upd_kind  (upd_kind),
      .upd_data  (upd_data)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      int    ch;
      int    kind;
      int    data;
      string req;
   } exp_t;
   exp_t sb[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic expect_upd(input int ch, input logic [15:0] w, input string req);
      exp_t e;
      e.ch = ch; e.kind = int'(w[15:14]); e.data = int'(w[13:0]); e.req = req;
      sb.push_back(e);
   endtask

   // scoreboard monitor
   bit prev_v = 1'b0;
   always @(negedge clk) begin
      if (rst_n && upd_valid) begin
         chk(!prev_v, "R10 single pulse", 1, 0);
         if (sb.size() == 0) begin
            chk(1'b0, "R3/R9 unexpected update", int'(upd_chan), -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(int'(upd_chan) == e.ch, {e.req, " chan"}, int'(upd_chan), e.ch);
            chk(int'(upd_kind) == e.kind, {e.req, " kind"}, int'(upd_kind), e.kind);
            chk(int'(upd_data) == e.data, {e.req, " data"}, int'(upd_data), e.data);
         end
      end
      prev_v = rst_n && upd_valid;
   end

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b0; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b1; qwait();
      qwait();
   endtask

   task automatic xfer(input logic [7:0] b, input bit exp_ack, input string req);
      bit acked;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qwait();
         m_scl = 1'b1; qwait(); qwait();
         m_scl = 1'b0; qwait();
      end
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      acked = (sda_bus == 1'b0);
      qwait();
      m_scl = 1'b0; qwait();
      chk(acked == exp_ack, req, int'(acked), int'(exp_ack));
   endtask

   task automatic send_word(input int ch, input logic [15:0] w, input string req);
      expect_upd(ch, w, req);
      xfer(w[15:8], 1'b1, "R4 data hi ack");
      xfer(w[7:0], 1'b1, "R4 data lo ack");
   endtask

   task automatic drain(input string req);
      repeat (20) @(negedge clk);
      chk(sb.size() == 0, req, sb.size(), 0);
   endtask

   localparam logic [7:0] ADDR_W = 8'hAC; // 10101 10 0

   initial begin
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 oe in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 oe after reset", int'(sda_oe), 0);
      chk(upd_valid == 1'b0, "R1 valid after reset", int'(upd_valid), 0);

      // single full frame
      bus_start();
      xfer(ADDR_W, 1'b1, "R2 address ack");
      xfer(8'h05, 1'b1, "R4 pointer ack");
      send_word(5, 16'h9ABC, "R5");
      bus_stop();
      drain("R5 all updates seen");

      // repeated pointer + data without re-addressing
      bus_start();
      xfer(ADDR_W, 1'b1, "R2 address ack");
      xfer(8'h03, 1'b1, "R4 pointer ack");
      send_word(3, 16'h4123, "R6 first");
      xfer(8'h0E, 1'b1, "R6 second pointer ack");
      send_word(14, 16'hFFFF, "R6 second");
      bus_stop();
      drain("R6 all updates seen");

      // wrong address: refused and everything after ignored
      bus_start();
      xfer(8'hAE, 1'b0, "R3 wrong address nack");
      xfer(8'h05, 1'b0, "R3 ignored byte nack");
      xfer(8'h12, 1'b0, "R3 ignored byte nack");
      xfer(8'h34, 1'b0, "R3 ignored byte nack");
      bus_stop();
      // read direction refused
      bus_start();
      xfer(8'hAD, 1'b0, "R3 read direction nack");
      xfer(8'h01, 1'b0, "R3 ignored byte nack");
      bus_stop();
      drain("R3 no update");

      // strap change, then repeated START with the new address
      addr_pins = 2'b01;
      bus_start();
      xfer(ADDR_W, 1'b0, "R3 old address nack");
      bus_start();
      xfer(8'hAA, 1'b1, "R2 strap address ack");
      xfer(8'h01, 1'b1, "R4 pointer ack");
      send_word(1, 16'h0007, "R2 strap update");
      bus_stop();
      drain("R2 strap updates seen");
      addr_pins = 2'b10;

      // full burst then fallback to pointer mode
      bus_start();
      xfer(ADDR_W, 1'b1, "R2 address ack");
      xfer(8'hFF, 1'b1, "R7 burst pointer ack");
      for (int ch = 0; ch < NUM_CHAN; ch++) begin
         logic [15:0] w;
         w = {2'(ch % 4), 14'(ch * 16'h0111 + 1)};
         send_word(ch, w, "R7 burst");
      end
      xfer(8'h02, 1'b1, "R8 pointer after burst ack");
      send_word(2, 16'h8005, "R8 pointer mode after burst");
      bus_stop();
      drain("R8 all updates seen");

      // STOP in the middle of a burst drops the half word
      bus_start();
      xfer(ADDR_W, 1'b1, "R2 address ack");
      xfer(8'hFF, 1'b1, "R7 burst pointer ack");
      send_word(0, 16'h1111, "R7 short burst");
      send_word(1, 16'h2222, "R7 short burst");
      send_word(2, 16'h3333, "R7 short burst");
      xfer(8'h44, 1'b1, "R4 half word ack");
      bus_stop();
      bus_start();
      xfer(ADDR_W, 1'b1, "R2 address ack");
      xfer(8'h09, 1'b1, "R4 pointer ack");
      send_word(9, 16'h1234, "R9 after stop");
      bus_stop();
      drain("R9 stop discards half word");

      // repeated START discards half word and expects an address
      bus_start();
      xfer(ADDR_W, 1'b1, "R2 address ack");
      xfer(8'h04, 1'b1, "R4 pointer ack");
      xfer(8'h55, 1'b1, "R4 half word ack");
      bus_start();
      xfer(ADDR_W, 1'b1, "R9 address after repeated start");
      xfer(8'h06, 1'b1, "R4 pointer ack");
      send_word(6, 16'hC00A, "R9 after repeated start");
      xfer(8'h03, 1'b1, "R4 pointer ack");
      bus_start();
      xfer(8'h07, 1'b0, "R9 pointer value taken as address nack");
      xfer(8'h12, 1'b0, "R3 ignored byte nack");
      bus_stop();
      drain("R9 repeated start discards");

      chk(sda_oe == 1'b0, "R1 oe idle at end", int'(sda_oe), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule